// File: doc/BRIEF.md
# Single-Cycle Integer Execute Unit

This block executes one 32-bit integer instruction word per clock. An upstream fetch stage presents the word with a valid strobe. In the same cycle the block does four things:

- splits the word into its fields;
- reads up to two source registers from a local 32 x 32-bit register file;
- computes an arithmetic, logic or shift result;
- writes that result into the destination register on the next rising clock edge.

There are two encodings. The register form carries a zero opcode and selects its operation through a 6-bit function field. The immediate form carries a non-zero opcode and a 16-bit constant. The register form writes to its third register field. The immediate form writes to its second register field.

Register 0 always reads zero, and writes to it are dropped. A word that does not decode raises an illegal flag for that cycle and leaves the register file unchanged. A combinational debug port returns any register. Through it a test or monitor can see the architectural state without disturbing execution.

Top module: `int_exec_unit`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads zero on the debug port until it is written.
- R2: Register 0 reads as zero at all times, and any instruction whose destination is register 0 leaves it zero.
- R3: The bit fields of an instruction word are op = [31:26], rs = [25:21], rt = [20:16], rd = [15:11], shamt = [10:6] and funct = [5:0]. With op = 0, funct 32 writes rs + rt to rd and funct 34 writes rs - rt to rd. Both wrap modulo 2^32.
- R4: With op = 0, the following funct values write to rd:

  | funct | result |
  |---|---|
  | 36 | rs AND rt |
  | 37 | rs OR rt |
  | 38 | rs XOR rt |
  | 39 | NOT(rs OR rt) |

  NOR with register 0 therefore gives bitwise NOT.
- R5: With op = 0, the following funct values write to rd the value of rt shifted by shamt:

  | funct | shift | vacated bits |
  |---|---|---|
  | 0 | left | zeros |
  | 2 | right | zeros |
  | 3 | right | copies of bit 31 |

  A shamt of 0 copies rt unchanged.
- R6: Opcode 8 writes to rt the value rs + sign-extended imm[15:0], modulo 2^32. A negative immediate is how a constant is subtracted.
- R7: Opcodes 12, 13 and 14 write to rt the value of rs combined with the zero-extended imm[15:0]. Opcode 12 uses AND, opcode 13 uses OR and opcode 14 uses XOR.
- R8: The write takes effect on the rising clock edge on which valid is high. With valid low nothing is written. In the cycle of a write, the debug port still returns the old value of the destination.
- R9: Any other opcode, and any op = 0 word with a funct not listed above, drives illegal_o high while valid is high and writes no register. With valid low, illegal_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears the register file |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| dbg_addr_i | input | 5 | Register index for the debug read |
| dbg_data_o | output | 32 | Current contents of the register selected by dbg_addr_i |
| illegal_o | output | 1 | Valid word that does not decode; no write occurs |

## Verification
The bench builds the unit with its default parameters: 32-bit data and 32 registers. These values make the full 5-bit register index range reachable, including register 0 and register 31. They also give a real bit 31 for the sign-extension, arithmetic-shift and wrap-around cases. The vector table covers the extremes of the immediate range, shifts by 0 and by 31, and writes aimed at register 0. Directed steps cover reads in the cycle of a write, words held with valid low, and reset applied in the middle of a run.

// File: rtl/iex_pkg.sv
package iex_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned SH_W    = 5;
  localparam int unsigned IMM_W   = 16;

  localparam logic [OP_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OP_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OP_W-1:0] OPC_ANDI = 6'd12;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OP_W-1:0] OPC_XORI = 6'd14;

  localparam logic [FN_W-1:0] FN_SLL = 6'd0;
  localparam logic [FN_W-1:0] FN_SRL = 6'd2;
  localparam logic [FN_W-1:0] FN_SRA = 6'd3;
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SRA
  } alu_op_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [IDX_W-1:0] rs;
    logic [IDX_W-1:0] rt;
    logic [IDX_W-1:0] rd;
    logic [SH_W-1:0]  shamt;
    logic [FN_W-1:0]  funct;
  } rfmt_t;
endpackage

// File: rtl/iex_decoder.sv
module iex_decoder
  import iex_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  valid_i,
  input  logic [INSTR_W-1:0]    instr_i,
  output alu_op_e               alu_op_o,
  output logic [IDX_W-1:0]      rs_o,
  output logic [IDX_W-1:0]      rt_o,
  output logic [IDX_W-1:0]      dest_o,
  output logic [SH_W-1:0]       shamt_o,
  output logic                  use_imm_o,
  output logic [DATA_W-1:0]     imm_o,
  output logic                  wr_en_o,
  output logic                  illegal_o
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  rfmt_t            f;
  logic [IMM_W-1:0] imm16;
  logic             legal;

  assign f     = rfmt_t'(instr_i);
  assign imm16 = instr_i[IMM_W-1:0];

  assign rs_o    = f.rs;
  assign rt_o    = f.rt;
  assign shamt_o = f.shamt;

  always_comb begin
    alu_op_o  = ALU_ADD;
    dest_o    = f.rd;
    use_imm_o = 1'b0;
    imm_o     = '0;
    legal     = 1'b1;
    if (f.op == OPC_REG) begin
      unique case (f.funct)
        FN_SLL:  alu_op_o = ALU_SLL;
        FN_SRL:  alu_op_o = ALU_SRL;
        FN_SRA:  alu_op_o = ALU_SRA;
        FN_ADD:  alu_op_o = ALU_ADD;
        FN_SUB:  alu_op_o = ALU_SUB;
        FN_AND:  alu_op_o = ALU_AND;
        FN_OR:   alu_op_o = ALU_OR;
        FN_XOR:  alu_op_o = ALU_XOR;
        FN_NOR:  alu_op_o = ALU_NOR;
        default: legal    = 1'b0;
      endcase
    end else begin
      dest_o    = f.rt;
      use_imm_o = 1'b1;
      imm_o     = {{EXT_W{1'b0}}, imm16};
      unique case (f.op)
        OPC_ADDI: begin
          alu_op_o = ALU_ADD;
          imm_o    = {{EXT_W{imm16[IMM_W-1]}}, imm16};
        end
        OPC_ANDI: alu_op_o = ALU_AND;
        OPC_ORI:  alu_op_o = ALU_OR;
        OPC_XORI: alu_op_o = ALU_XOR;
        default:  legal    = 1'b0;
      endcase
    end
  end

  assign wr_en_o   = valid_i & legal;
  assign illegal_o = valid_i & ~legal;
endmodule

// File: rtl/iex_alu.sv
module iex_alu
  import iex_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e             op_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [SH_W-1:0]     shamt_i,
  output logic [DATA_W-1:0]   res_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_XOR: res_o = a_i ^ b_i;
      ALU_NOR: res_o = ~(a_i | b_i);
      ALU_SLL: res_o = b_i << shamt_i;
      ALU_SRL: res_o = b_i >> shamt_i;
      ALU_SRA: res_o = $signed(b_i) >>> shamt_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/iex_regfile.sv
module iex_regfile #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_RD   = 3,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 waddr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_RD-1:0][AW-1:0]     raddr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdata_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  // entry 0 is never written; it stays at its reset value of zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : regs_q[raddr_i[p]];
  end

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q));

  p_zero_discard_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == '0) |=> $stable(regs_q));

  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iex_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [31:0]        instr_i,
  input  logic [AW-1:0]      dbg_addr_i,
  output logic [DATA_W-1:0]  dbg_data_o,
  output logic               illegal_o
);
  localparam int unsigned RD_PORTS = 3;

  alu_op_e                            alu_op;
  logic [IDX_W-1:0]                   rs_idx, rt_idx, dest_idx;
  logic [SH_W-1:0]                    shamt;
  logic                               use_imm;
  logic [DATA_W-1:0]                  imm;
  logic                               wr_en;
  logic [RD_PORTS-1:0][AW-1:0]        raddr;
  logic [RD_PORTS-1:0][DATA_W-1:0]    rdata;
  logic [DATA_W-1:0]                  opnd_a, opnd_b, alu_res;

  iex_decoder #(.DATA_W(DATA_W)) u_dec (
    .valid_i   (instr_valid_i),
    .instr_i   (instr_i),
    .alu_op_o  (alu_op),
    .rs_o      (rs_idx),
    .rt_o      (rt_idx),
    .dest_o    (dest_idx),
    .shamt_o   (shamt),
    .use_imm_o (use_imm),
    .imm_o     (imm),
    .wr_en_o   (wr_en),
    .illegal_o (illegal_o)
  );

  assign raddr[0] = AW'(rs_idx);
  assign raddr[1] = AW'(rt_idx);
  assign raddr[2] = dbg_addr_i;

  iex_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_RD(RD_PORTS)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .waddr_i (AW'(dest_idx)),
    .wdata_i (alu_res),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign opnd_a = rdata[0];
  assign opnd_b = use_imm ? imm : rdata[1];

  iex_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (alu_op),
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .shamt_i (shamt),
    .res_o   (alu_res)
  );

  assign dbg_data_o = rdata[2];

  p_illegal_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_en);

  p_illegal_needs_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> !illegal_o);

  p_nor_disjoint_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && instr_i[31:26] == OPC_REG && instr_i[5:0] == FN_NOR)
      |-> ((alu_res & (opnd_a | opnd_b)) == '0));

  p_sra_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && instr_i[31:26] == OPC_REG && instr_i[5:0] == FN_SRA)
      |-> (alu_res[DATA_W-1] == rdata[1][DATA_W-1]));

  p_addi_from_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && instr_i[31:26] == OPC_ADDI && instr_i[25:21] == '0)
      |-> (alu_res == DATA_W'($signed(instr_i[15:0]))));

  p_dbg_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_addr_i == '0) |-> (dbg_data_o == '0));
endmodule

// File: tb/int_exec_unit_tb_top.sv
`timescale 1ns/1ps
module int_exec_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [4:0]  dbg_addr_i = '0;
  logic [31:0] dbg_data_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  int_exec_unit dut_i (
    .clk_i, .rst_ni, .instr_valid_i, .instr_i, .dbg_addr_i, .dbg_data_o, .illegal_o
  );

  function automatic logic [31:0] rt_w(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] it_w(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [4:0]  reg_no;
    logic [31:0] exp;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{it_w(8, 0, 1, 100),      5'd1,  32'd100,        1'b0, 4'd6},  // R6
    '{it_w(8, 0, 2, -1),       5'd2,  32'hFFFF_FFFF,  1'b0, 4'd6},  // R6 sign extend
    '{rt_w(1, 2, 3, 0, 32),    5'd3,  32'd99,         1'b0, 4'd3},  // R3 add wraps
    '{it_w(13, 0, 4, 'h8000),  5'd4,  32'h0000_8000,  1'b0, 4'd7},  // R7 ori zero ext
    '{it_w(12, 2, 5, 'hF0F0),  5'd5,  32'h0000_F0F0,  1'b0, 4'd7},  // R7 andi
    '{it_w(14, 2, 6, 'h00FF),  5'd6,  32'hFFFF_FF00,  1'b0, 4'd7},  // R7 xori
    '{rt_w(1, 3, 7, 0, 34),    5'd7,  32'd1,          1'b0, 4'd3},  // R3 sub
    '{rt_w(0, 1, 8, 0, 34),    5'd8,  32'hFFFF_FF9C,  1'b0, 4'd3},  // R3 sub negative
    '{rt_w(2, 2, 9, 0, 32),    5'd9,  32'hFFFF_FFFE,  1'b0, 4'd3},  // R3 wrap
    '{it_w(8, 0, 10, 'h3C00),  5'd10, 32'h0000_3C00,  1'b0, 4'd6},  // R6
    '{it_w(8, 0, 11, 'h0DC0),  5'd11, 32'h0000_0DC0,  1'b0, 4'd6},  // R6
    '{rt_w(10, 11, 12, 0, 36), 5'd12, 32'h0000_0C00,  1'b0, 4'd4},  // R4 and
    '{rt_w(10, 11, 13, 0, 37), 5'd13, 32'h0000_3DC0,  1'b0, 4'd4},  // R4 or
    '{rt_w(10, 11, 14, 0, 38), 5'd14, 32'h0000_31C0,  1'b0, 4'd4},  // R4 xor
    '{rt_w(10, 0, 15, 0, 39),  5'd15, 32'hFFFF_C3FF,  1'b0, 4'd4},  // R4 nor as not
    '{rt_w(0, 1, 16, 4, 0),    5'd16, 32'h0000_0640,  1'b0, 4'd5},  // R5 sll
    '{rt_w(0, 8, 17, 4, 2),    5'd17, 32'h0FFF_FFF9,  1'b0, 4'd5},  // R5 srl
    '{rt_w(0, 8, 18, 4, 3),    5'd18, 32'hFFFF_FFF9,  1'b0, 4'd5},  // R5 sra negative
    '{rt_w(0, 11, 19, 4, 3),   5'd19, 32'h0000_00DC,  1'b0, 4'd5},  // R5 sra positive
    '{rt_w(0, 2, 20, 31, 0),   5'd20, 32'h8000_0000,  1'b0, 4'd5},  // R5 sll by 31
    '{rt_w(0, 8, 21, 0, 2),    5'd21, 32'hFFFF_FF9C,  1'b0, 4'd5},  // R5 shamt 0
    '{rt_w(0, 8, 31, 31, 3),   5'd31, 32'hFFFF_FFFF,  1'b0, 4'd5},  // R5 sra by 31
    '{it_w(8, 1, 22, -100),    5'd22, 32'd0,          1'b0, 4'd6},  // R6 subtract constant
    '{it_w(8, 0, 23, 32767),   5'd23, 32'h0000_7FFF,  1'b0, 4'd6},  // R6 max imm
    '{it_w(8, 0, 24, -32768),  5'd24, 32'hFFFF_8000,  1'b0, 4'd6},  // R6 min imm
    '{rt_w(1, 1, 0, 0, 32),    5'd0,  32'd0,          1'b0, 4'd2},  // R2 add to r0
    '{it_w(8, 0, 0, 55),       5'd0,  32'd0,          1'b0, 4'd2},  // R2 addi to r0
    '{rt_w(1, 1, 25, 0, 1),    5'd25, 32'd0,          1'b1, 4'd9},  // R9 bad funct
    '{it_w(35, 1, 26, 4),      5'd26, 32'd0,          1'b1, 4'd9},  // R9 bad opcode
    '{rt_w(1, 1, 27, 0, 33),   5'd27, 32'd0,          1'b1, 4'd9},  // R9 funct 33
    '{it_w(9, 0, 28, 1),       5'd28, 32'd0,          1'b1, 4'd9}   // R9 opcode 9
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    #5;
    dbg_addr_i = 5'd1;
    #1 chk(1, dbg_data_o, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int r = 0; r < 32; r += 7) begin
      dbg_addr_i = 5'(r);
      #1 chk(1, dbg_data_o, 32'd0);
    end

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      instr_i = VECS[i].ins;
      instr_valid_i = 1'b1;
      dbg_addr_i = VECS[i].reg_no;
      #2 chk(VECS[i].req == 4'd9 ? 9 : 8, {31'd0, illegal_o}, {31'd0, VECS[i].ill});
      @(posedge clk_i);
      #2 instr_valid_i = 1'b0;
      chk(VECS[i].req, dbg_data_o, VECS[i].exp);
    end

    // R8: old value visible in the write cycle, new after the edge
    @(negedge clk_i);
    dbg_addr_i = 5'd1;
    instr_i = it_w(8, 0, 1, 7);
    instr_valid_i = 1'b1;
    #2 chk(8, dbg_data_o, 32'd100);
    @(posedge clk_i);
    #2 instr_valid_i = 1'b0;
    chk(8, dbg_data_o, 32'd7);

    // R8: valid low, no write
    @(negedge clk_i);
    instr_i = it_w(8, 0, 1, 5);
    instr_valid_i = 1'b0;
    repeat (2) @(posedge clk_i);
    #2 chk(8, dbg_data_o, 32'd7);

    // R9: illegal word held with valid low gives no flag
    @(negedge clk_i);
    instr_i = it_w(35, 0, 2, 0);
    #2 chk(9, {31'd0, illegal_o}, 32'd0);

    // R1: reset in mid-run clears written registers
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    dbg_addr_i = 5'd1;
    #1 chk(1, dbg_data_o, 32'd0);
    dbg_addr_i = 5'd31;
    #1 chk(1, dbg_data_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #2 chk(1, dbg_data_o, 32'd0);

    finish_run();
  end
endmodule